// File: doc/BRIEF.md
# Bus Hold and Back-off Relay

This block sits between the processor-side and system-side bus handshake lines of a secondary cache controller. Four indications cross it with a fixed one-clock delay: hold acknowledge, hit-modified, back-off and the write-back/write-through flag. Hold acknowledge is blocked whenever the cache owns the bus to write back a dirty line. The cache back-off output is raised by the system back-off input and also by an eviction request from the cache controller. In the eviction case it stays raised until the controller's write-back finishes.

While system back-off is asserted, new memory cycles from the processor are not accepted. Snoop and invalidation requests are still accepted. A snoop that hits a dirty line is held pending and released for data supply only once back-off is gone. During reset the block broadcasts its configuration. The hit-modified output carries the lead-off wait-state mode and the memory-start output is held high as a presence indication. The level of the cacheable-data input on the last reset clock sets the write-allocation enable.

Top module: `hold_backoff_relay`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs are `cache_backoff_n`=1, `wbwt_out_n`=1, `mem_start_n`=1, `hold_ack_out`=0, `mem_cycle_go`=0, `snoop_go`=0 and `supply_go`=0.
- R2: While in reset, `hitm_out_n` shows the inverse of `cfg_lead_wait` (0 means one lead-off wait state). Outside reset, it equals `cpu_hitm_n` from the previous clock.
- R3: `wr_alloc_en` takes the inverse of `sys_cacheable_n` as sampled on the last clock with `rst` high, and holds that value until the next reset.
- R4: When no write-back ownership is active and `wb_active` is 0, `hold_ack_out` equals `cpu_hlda` from the previous clock.
- R5: `cache_backoff_n` goes low one clock after `evict_req` is sampled high. It stays low until the first clock on which `wb_active` falls after having been seen high during that ownership, and it returns high one clock after that fall unless `sys_backoff_n` is low.
- R6: `hold_ack_out` is 0 one clock after any cycle that either has `wb_active` high or lies in write-back ownership (the span from R5). It then follows `cpu_hlda` again once ownership ends.
- R7: A low `sys_backoff_n` drives `cache_backoff_n` low one clock later, with or without an eviction.
- R8: `wbwt_out_n` equals `sys_wbwt_n` from the previous clock, so a low input forces a low output one clock later.
- R9: `mem_start_n` is low exactly one clock after each cycle with `evict_req` high, and high otherwise.
- R10: `mem_cycle_go` is 1 one clock after a cycle with `mem_cycle_req` high and `sys_backoff_n` high. `snoop_go` is 1 one clock after any cycle with `snoop_req` high, whatever the back-off state.
- R11: A cycle with `snoop_dirty_hit` high makes a dirty supply pending. `supply_go` pulses one clock after the first cycle, counting that cycle itself, in which supply is pending and `sys_backoff_n` is high; that pulse clears the pending supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lead_wait | input | 1 | Mode: 1 selects one lead-off wait state |
| sys_cacheable_n | input | 1 | Cacheable-data input, low enables write allocation at reset |
| sys_backoff_n | input | 1 | System back-off, active low |
| cpu_hlda | input | 1 | Processor hold acknowledge, active high |
| cpu_hitm_n | input | 1 | Processor hit-modified, active low |
| sys_wbwt_n | input | 1 | System write-back (1) / write-through (0) flag |
| wb_active | input | 1 | Controller is writing back a dirty line |
| evict_req | input | 1 | Controller requests a dirty-line eviction |
| mem_cycle_req | input | 1 | Processor starts a memory cycle |
| snoop_req | input | 1 | External snoop or invalidation strobe |
| snoop_dirty_hit | input | 1 | A snoop hit a dirty line that needs data supply |
| cache_backoff_n | output | 1 | Back-off to the processor, active low |
| hold_ack_out | output | 1 | Relayed hold acknowledge |
| hitm_out_n | output | 1 | Relayed hit-modified, mode during reset |
| wbwt_out_n | output | 1 | Relayed write-back/write-through flag |
| mem_start_n | output | 1 | Memory start for a write-back, high during reset |
| wr_alloc_en | output | 1 | Write allocation enable latched at reset |
| mem_cycle_go | output | 1 | Memory cycle accepted |
| snoop_go | output | 1 | Snoop or invalidation accepted |
| supply_go | output | 1 | Dirty snoop data may now be supplied |

## Verification
On every cycle, the assertions check the one-clock relays of hit-modified and write-back/write-through. They also check that back-off follows both of its causes, that hold acknowledge is blocked during a write-back, that memory acceptance and data supply never occur under back-off, and that the write-allocation enable stays stable. Several behaviours can only be shown by the bench's scenarios: how long ownership lasts from an eviction request to the fall of `wb_active`, that hold acknowledge resumes after that fall, that a dirty supply stays pending across a long back-off, and the mode and allocation values seen across two resets with opposite settings.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    // Write-back ownership phases
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,   // bus not owned for a write-back
        OWN_WAIT = 2'd1,   // eviction requested, write-back not yet started
        OWN_XFER = 2'd2    // write-back transfer in progress
    } own_state_e;

    // Bundle of relayed handshake outputs
    typedef struct packed {
        logic backoff_n;
        logic hold;
        logic hitm_n;
        logic wbwt_n;
        logic start_n;
    } relay_t;

    // Bundle of cycle-acceptance outputs
    typedef struct packed {
        logic mem_go;
        logic snoop_go;
    } accept_t;

    // Output values broadcast while reset is held
    function automatic relay_t relay_reset(input logic lead_wait);
        relay_t r;
        r.backoff_n = 1'b1;
        r.hold      = 1'b0;
        r.hitm_n    = ~lead_wait;
        r.wbwt_n    = 1'b1;
        r.start_n   = 1'b1;
        return r;
    endfunction

    // Next ownership phase
    function automatic own_state_e own_next(input own_state_e st,
                                            input logic evict,
                                            input logic wb);
        own_state_e n;
        case (st)
            OWN_IDLE: n = evict ? (wb ? OWN_XFER : OWN_WAIT) : OWN_IDLE;
            OWN_WAIT: n = wb ? OWN_XFER : OWN_WAIT;
            OWN_XFER: n = wb ? OWN_XFER : (evict ? OWN_WAIT : OWN_IDLE);
            default:  n = OWN_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hbr_owner_fsm.sv
module hbr_owner_fsm
    import hbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evict_req,
    input  logic wb_active,
    output logic own_now,
    output logic hold_block
);

    own_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= OWN_IDLE;
        else     st_q <= own_next(st_q, evict_req, wb_active);
    end

    // Ownership covers the request cycle, the wait for the transfer,
    // and the transfer itself up to the cycle in which it ends.
    always_comb begin
        own_now = evict_req
                | (st_q == OWN_WAIT)
                | ((st_q == OWN_XFER) & wb_active);
        hold_block = own_now | wb_active;
    end

endmodule

// File: rtl/hbr_supply_gate.sv
module hbr_supply_gate (
    input  logic clk,
    input  logic rst,
    input  logic dirty_hit,
    input  logic backoff_n,
    output logic supply_go
);

    logic pend_q;
    logic pend_nx;
    logic fire;

    always_comb begin
        pend_nx = dirty_hit | pend_q;
        fire    = pend_nx & backoff_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            supply_go <= 1'b0;
        end else begin
            pend_q    <= pend_nx & ~fire;
            supply_go <= fire;
        end
    end

endmodule

// File: rtl/hbr_cfg_latch.sv
module hbr_cfg_latch (
    input  logic clk,
    input  logic rst,
    input  logic cacheable_n,
    output logic alloc_en
);

    // Resampled on every reset clock; the last one before release sticks.
    always_ff @(posedge clk) begin
        if (rst) alloc_en <= ~cacheable_n;
    end

endmodule

// File: rtl/hold_backoff_relay.sv
module hold_backoff_relay
    import hbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_lead_wait,
    input  logic sys_cacheable_n,
    input  logic sys_backoff_n,
    input  logic cpu_hlda,
    input  logic cpu_hitm_n,
    input  logic sys_wbwt_n,
    input  logic wb_active,
    input  logic evict_req,
    input  logic mem_cycle_req,
    input  logic snoop_req,
    input  logic snoop_dirty_hit,
    output logic cache_backoff_n,
    output logic hold_ack_out,
    output logic hitm_out_n,
    output logic wbwt_out_n,
    output logic mem_start_n,
    output logic wr_alloc_en,
    output logic mem_cycle_go,
    output logic snoop_go,
    output logic supply_go
);

    logic    own_now;
    logic    hold_block;
    relay_t  relay_nx;
    relay_t  relay_q;
    accept_t accept_nx;
    accept_t accept_q;

    hbr_owner_fsm u_owner (
        .clk        (clk),
        .rst        (rst),
        .evict_req  (evict_req),
        .wb_active  (wb_active),
        .own_now    (own_now),
        .hold_block (hold_block)
    );

    hbr_supply_gate u_supply (
        .clk       (clk),
        .rst       (rst),
        .dirty_hit (snoop_dirty_hit),
        .backoff_n (sys_backoff_n),
        .supply_go (supply_go)
    );

    hbr_cfg_latch u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cacheable_n (sys_cacheable_n),
        .alloc_en    (wr_alloc_en)
    );

    always_comb begin
        relay_nx.backoff_n = sys_backoff_n & ~own_now;
        relay_nx.hold      = cpu_hlda & ~hold_block;
        relay_nx.hitm_n    = cpu_hitm_n;
        relay_nx.wbwt_n    = sys_wbwt_n;
        relay_nx.start_n   = ~evict_req;
        accept_nx.mem_go   = mem_cycle_req & sys_backoff_n;
        accept_nx.snoop_go = snoop_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            relay_q  <= relay_reset(cfg_lead_wait);
            accept_q <= '0;
        end else begin
            relay_q  <= relay_nx;
            accept_q <= accept_nx;
        end
    end

    assign cache_backoff_n = relay_q.backoff_n;
    assign hold_ack_out    = relay_q.hold;
    assign hitm_out_n      = relay_q.hitm_n;
    assign wbwt_out_n      = relay_q.wbwt_n;
    assign mem_start_n     = relay_q.start_n;
    assign mem_cycle_go    = accept_q.mem_go;
    assign snoop_go        = accept_q.snoop_go;

endmodule

// File: rtl/hbr_checker.sv
module hbr_checker (
    input logic clk,
    input logic rst,
    input logic sys_cacheable_n,
    input logic sys_backoff_n,
    input logic cpu_hlda,
    input logic cpu_hitm_n,
    input logic sys_wbwt_n,
    input logic wb_active,
    input logic evict_req,
    input logic mem_cycle_req,
    input logic cache_backoff_n,
    input logic hold_ack_out,
    input logic hitm_out_n,
    input logic wbwt_out_n,
    input logic mem_start_n,
    input logic wr_alloc_en,
    input logic mem_cycle_go,
    input logic supply_go
);

    assert_hitm_relay_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> hitm_out_n == $past(cpu_hitm_n));

    assert_alloc_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(wr_alloc_en));

    assert_hold_source_R4: assert property (@(posedge clk) disable iff (rst)
        hold_ack_out |-> $past(cpu_hlda));

    assert_evict_backoff_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(evict_req)) |-> !cache_backoff_n);

    assert_hold_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wb_active)) |-> !hold_ack_out);

    assert_sys_backoff_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sys_backoff_n)) |-> !cache_backoff_n);

    assert_wbwt_relay_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> wbwt_out_n == $past(sys_wbwt_n));

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_start_n |-> $past(evict_req));

    assert_mem_accept_R10: assert property (@(posedge clk) disable iff (rst)
        mem_cycle_go |-> ($past(mem_cycle_req) && $past(sys_backoff_n)));

    assert_supply_free_R11: assert property (@(posedge clk) disable iff (rst)
        supply_go |-> $past(sys_backoff_n));

endmodule

bind hold_backoff_relay hbr_checker u_hbr_checker (
    .clk             (clk),
    .rst             (rst),
    .sys_cacheable_n (sys_cacheable_n),
    .sys_backoff_n   (sys_backoff_n),
    .cpu_hlda        (cpu_hlda),
    .cpu_hitm_n      (cpu_hitm_n),
    .sys_wbwt_n      (sys_wbwt_n),
    .wb_active       (wb_active),
    .evict_req       (evict_req),
    .mem_cycle_req   (mem_cycle_req),
    .cache_backoff_n (cache_backoff_n),
    .hold_ack_out    (hold_ack_out),
    .hitm_out_n      (hitm_out_n),
    .wbwt_out_n      (wbwt_out_n),
    .mem_start_n     (mem_start_n),
    .wr_alloc_en     (wr_alloc_en),
    .mem_cycle_go    (mem_cycle_go),
    .supply_go       (supply_go)
);

// File: tb/sim_hold_backoff_relay.sv
`timescale 1ns/1ps
module sim_hold_backoff_relay;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_lead_wait = 1'b1;
    logic sys_cacheable_n = 1'b0;
    logic sys_backoff_n = 1'b1;
    logic cpu_hlda = 1'b0;
    logic cpu_hitm_n = 1'b1;
    logic sys_wbwt_n = 1'b1;
    logic wb_active = 1'b0;
    logic evict_req = 1'b0;
    logic mem_cycle_req = 1'b0;
    logic snoop_req = 1'b0;
    logic snoop_dirty_hit = 1'b0;

    logic cache_backoff_n, hold_ack_out, hitm_out_n, wbwt_out_n, mem_start_n;
    logic wr_alloc_en, mem_cycle_go, snoop_go, supply_go;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int   ph = 0;          // 0 idle, 1 waiting for write-back, 2 transferring
    bit   pend = 0;
    logic e_bo_n, e_hold, e_hitm_n, e_wbwt_n, e_start_n, e_alloc;
    logic e_mgo, e_sgo, e_sup;

    always #2 clk = ~clk;

    hold_backoff_relay u0 (
        .clk (clk), .rst (rst), .cfg_lead_wait (cfg_lead_wait),
        .sys_cacheable_n (sys_cacheable_n), .sys_backoff_n (sys_backoff_n),
        .cpu_hlda (cpu_hlda), .cpu_hitm_n (cpu_hitm_n), .sys_wbwt_n (sys_wbwt_n),
        .wb_active (wb_active), .evict_req (evict_req),
        .mem_cycle_req (mem_cycle_req), .snoop_req (snoop_req),
        .snoop_dirty_hit (snoop_dirty_hit),
        .cache_backoff_n (cache_backoff_n), .hold_ack_out (hold_ack_out),
        .hitm_out_n (hitm_out_n), .wbwt_out_n (wbwt_out_n),
        .mem_start_n (mem_start_n), .wr_alloc_en (wr_alloc_en),
        .mem_cycle_go (mem_cycle_go), .snoop_go (snoop_go), .supply_go (supply_go)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Model update from the inputs present at the clock edge
    task automatic model_edge();
        bit owned;
        bit fire;
        if (rst) begin
            e_bo_n = 1; e_hold = 0; e_hitm_n = !cfg_lead_wait; e_wbwt_n = 1;
            e_start_n = 1; e_alloc = !sys_cacheable_n;
            e_mgo = 0; e_sgo = 0; e_sup = 0; ph = 0; pend = 0;
        end else begin
            owned = evict_req || ph == 1 || (ph == 2 && wb_active);
            e_bo_n   = sys_backoff_n && !owned;
            e_hold   = cpu_hlda && !owned && !wb_active;
            e_hitm_n = cpu_hitm_n;
            e_wbwt_n = sys_wbwt_n;
            e_start_n = !evict_req;
            e_mgo = mem_cycle_req && sys_backoff_n;
            e_sgo = snoop_req;
            fire  = (pend || snoop_dirty_hit) && sys_backoff_n;
            e_sup = fire;
            pend  = (pend || snoop_dirty_hit) && !fire;
            if (ph == 0)      ph = evict_req ? (wb_active ? 2 : 1) : 0;
            else if (ph == 1) ph = wb_active ? 2 : 1;
            else              ph = wb_active ? 2 : (evict_req ? 1 : 0);
        end
    endtask

    task automatic compare_all();
        chk("R1/R5/R7 cache_backoff_n", cache_backoff_n, e_bo_n);
        chk("R4/R6 hold_ack_out", hold_ack_out, e_hold);
        chk("R2 hitm_out_n", hitm_out_n, e_hitm_n);
        chk("R8 wbwt_out_n", wbwt_out_n, e_wbwt_n);
        chk("R9 mem_start_n", mem_start_n, e_start_n);
        chk("R3 wr_alloc_en", wr_alloc_en, e_alloc);
        chk("R10 mem_cycle_go", mem_cycle_go, e_mgo);
        chk("R10 snoop_go", snoop_go, e_sgo);
        chk("R11 supply_go", supply_go, e_sup);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // First reset: one wait state, write allocation enabled
        for (int i = 0; i < 3; i++) step();
        chk("R1 reset backoff", cache_backoff_n, 1'b1);
        chk("R1 reset start", mem_start_n, 1'b1);
        chk("R1 reset hold", hold_ack_out, 1'b0);
        chk("R2 reset mode", hitm_out_n, 1'b0);
        rst = 0; cpu_hlda = 1;
        step();
        chk("R1 first clock out of reset wbwt", wbwt_out_n, 1'b1);
        chk("R3 alloc enabled", wr_alloc_en, 1'b1);
        step();
        chk("R4 hold relayed", hold_ack_out, 1'b1);

        // Directed eviction with hold acknowledge held high
        evict_req = 1; step();
        evict_req = 0;
        chk("R5 backoff after evict", cache_backoff_n, 1'b0);
        chk("R9 start after evict", mem_start_n, 1'b0);
        chk("R6 hold blocked", hold_ack_out, 1'b0);
        step(); step();
        chk("R5 ownership held before write-back", cache_backoff_n, 1'b0);
        wb_active = 1; step(); step(); step();
        chk("R5 ownership during write-back", cache_backoff_n, 1'b0);
        chk("R9 start single pulse", mem_start_n, 1'b1);
        wb_active = 0; step();
        chk("R5 released after write-back", cache_backoff_n, 1'b1);
        chk("R6 hold resumes", hold_ack_out, 1'b1);

        // Back-off from the system with a pending dirty supply
        sys_backoff_n = 0; snoop_dirty_hit = 1; snoop_req = 1; mem_cycle_req = 1;
        step();
        snoop_dirty_hit = 0;
        chk("R7 backoff relayed", cache_backoff_n, 1'b0);
        chk("R10 memory refused", mem_cycle_go, 1'b0);
        chk("R10 snoop accepted", snoop_go, 1'b1);
        for (int i = 0; i < 4; i++) step();
        chk("R11 supply held", supply_go, 1'b0);
        sys_backoff_n = 1; step();
        chk("R11 supply released", supply_go, 1'b1);
        chk("R10 memory accepted", mem_cycle_go, 1'b1);
        step();
        chk("R11 supply single pulse", supply_go, 1'b0);

        // Relays of write-through and hit-modified
        sys_wbwt_n = 0; cpu_hitm_n = 0; step();
        chk("R8 write-through forced", wbwt_out_n, 1'b0);
        chk("R2 hitm relayed", hitm_out_n, 1'b0);
        sys_wbwt_n = 1; cpu_hitm_n = 1; snoop_req = 0; mem_cycle_req = 0; step();

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            sys_backoff_n   = ($urandom % 4) != 0;
            cpu_hlda        = $urandom % 2;
            cpu_hitm_n      = $urandom % 2;
            sys_wbwt_n      = $urandom % 2;
            evict_req       = ($urandom % 16) == 0;
            if (($urandom % 6) == 0) wb_active = !wb_active;
            mem_cycle_req   = $urandom % 2;
            snoop_req       = $urandom % 2;
            snoop_dirty_hit = ($urandom % 8) == 0;
            step();
        end

        // Second reset: no wait state, write allocation disabled
        rst = 1; cfg_lead_wait = 0; sys_cacheable_n = 1;
        step(); step();
        chk("R2 reset mode no wait", hitm_out_n, 1'b1);
        chk("R1 reset supply", supply_go, 1'b0);
        rst = 0; sys_cacheable_n = 0;
        step();
        chk("R3 alloc disabled", wr_alloc_en, 1'b0);
        for (int i = 0; i < 5; i++) step();
        chk("R3 alloc held", wr_alloc_en, 1'b0);
        finish_run();
    end

endmodule